// File: doc/BRIEF.md
# JTAG Chain Scan Master

This block drives a daisy chain of JTAG test access ports from a simple command interface, so that one target port in the chain can be addressed while every other port sits in bypass. It generates the test clock from the system clock through a programmable divider. It drives the mode-select and data-in lines, samples the data-out line and walks the port state machine itself. A host issues instruction scans, data scans and port resets, then reads back only the bits that belong to the target port.

Every scan is framed with filler bits. The count of leading filler bits (those pushed in first) covers the ports between the target and the chain's data-out pin. The count of trailing filler bits covers the ports between the chain's data-in pin and the target. Instruction and data scans have separate pairs of counts. For an instruction scan the counts are summed instruction lengths. For a data scan they are port counts, because a bypassed port holds one bit. After each operation the block can add trailing idle clocks in Run-Test/Idle. Port reset can use the dedicated reset line, or mode-select alone when the reset line must stay quiet.

Top module: `jscan_master`

## Requirements
- R1: After reset `busy`, `done`, `tck` and `scan_dout` are zero, `trst_n` is one, and the stored clock half-period equals CLK_HZ / (2 * TCK_HZ_DEF) system cycles (50 with the defaults, giving a 1000 kHz test clock).
- R2: While an operation runs, each `tck` period lasts 2 * half system cycles, where half is the stored setting. Settings are stored on `cfg_we` only while not busy. A `cfg_we` pulse while busy leaves all stored settings unchanged.
- R3: An instruction scan drives `tms` 1,1,0,0 from Run-Test/Idle. It then shifts ir_pre ones, then `scan_len` bits of `scan_din` (bit 0 first), then ir_post ones. `tms` is 1 on the last shifted bit. It finishes with `tms` 1,0 and ends in Run-Test/Idle.
- R4: A data scan works the same way, but its entry sequence is `tms` 1,0,0, its counts are dr_pre and dr_post, and its filler bits are zeros. The instruction counts have no effect on a data scan, and the data counts have no effect on an instruction scan.
- R5: `scan_dout[i]` holds the bit sampled on `tdo` at the (pre+i)-th shifted clock, counted from 0, for i below `scan_len` (1 to 64). All higher bits of `scan_dout` are zero.
- R6: After returning to Run-Test/Idle, the block adds `cfg_idle` extra clocks (0 to 255) with `tms` low. The total number of `tck` rising edges is entry + pre + len + post + 2 + idle.
- R7: A port reset with the reset line enabled drives `tms` high for five clocks with `trst_n` low during exactly those five rising edges. It then drives one clock with `tms` low, followed by the idle clocks.
- R8: With `cfg_no_trst` set, `trst_n` never goes low. A port reset then brings the ports from any state to Run-Test/Idle using `tms` alone.
- R9: A `start` or `tap_reset` pulse that arrives while busy is ignored. No further clocks follow the running operation, and its result is unchanged.
- R10: `done` pulses for one system cycle when an operation ends. `busy` is low in that same cycle.
- R11: `tms` and `tdi` change only together with a falling `tck`. `tdo` is sampled on the rising `tck`. `tck` is low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Store the configuration inputs (ignored while busy) |
| cfg_half | input | 16 | Test clock half-period in system cycles (0 treated as 1) |
| cfg_ir_pre | input | 8 | Leading filler bits for instruction scans |
| cfg_ir_post | input | 8 | Trailing filler bits for instruction scans |
| cfg_dr_pre | input | 8 | Leading filler bits for data scans |
| cfg_dr_post | input | 8 | Trailing filler bits for data scans |
| cfg_idle | input | 8 | Extra idle clocks after each operation |
| cfg_no_trst | input | 1 | Keep the reset line inactive; reset through mode-select only |
| start | input | 1 | Start a scan |
| tap_reset | input | 1 | Start a port reset (wins over start) |
| scan_ir | input | 1 | 1 selects an instruction scan, 0 a data scan |
| scan_len | input | 7 | Target scan length, 1 to 64 |
| scan_din | input | 64 | Target bits to shift in, bit 0 first |
| tdo | input | 1 | Serial data from the chain |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| scan_dout | output | 64 | Target bits captured from the chain |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Serial data to the chain |
| trst_n | output | 1 | Active-low test reset |

## Verification
The hardest cases to reach from the ports are the framing boundaries. Examples are a target length of one or sixty-four, no leading or trailing filler, and a port reset issued when the ports are stranded in a pause state. The bench models the whole chain behind the block. That model is a state tracker plus a shift path as long as the padded scan, loaded at capture with a known bit pattern. This lets it check which bits the block sends, which bits it keeps, and where the ports end up. It places the ports in a pause state directly before the mode-select-only reset, and it fires a second start and a configuration write partway through a running scan.

// File: rtl/jscan_pkg.sv
package jscan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NAV,
    ST_SHIFT,
    ST_EXIT,
    ST_RTI,
    ST_RST
  } jscan_st_e;

  typedef struct packed {
    logic [15:0] half;
    logic [7:0]  ir_pre;
    logic [7:0]  ir_post;
    logic [7:0]  dr_pre;
    logic [7:0]  dr_post;
    logic [7:0]  idle;
    logic        no_trst;
  } jscan_cfg_t;

endpackage

// File: rtl/jscan_cfg_regs.sv
module jscan_cfg_regs
  import jscan_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int TCK_HZ_DEF = 1_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       busy,
  input  jscan_cfg_t cfg_in,
  output jscan_cfg_t cfg_q
);

  localparam int DEF_HALF = CLK_HZ / (2 * TCK_HZ_DEF);

  jscan_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we && !busy) cfg_d = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q         <= '0;
      cfg_q.half    <= 16'(DEF_HALF);
    end else begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/jscan_tck_div.sv
module jscan_tck_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d, half_m1;

  always_comb begin
    half_m1 = (half == '0) ? '0 : half - 1'b1;
    tick    = run && (cnt_q == '0);
    cnt_d   = cnt_q;
    if (restart)       cnt_d = half_m1;
    else if (run)      cnt_d = (cnt_q == '0) ? half_m1 : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/jscan_seq.sv
module jscan_seq
  import jscan_pkg::*;
#(
  parameter int MAXLEN = 64,
  parameter int PAD_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  jscan_cfg_t                   cfg,
  input  logic                         start,
  input  logic                         tap_reset,
  input  logic                         scan_ir,
  input  logic [$clog2(MAXLEN+1)-1:0]  scan_len,
  input  logic [MAXLEN-1:0]            scan_din,
  input  logic                         tick,
  input  logic                         tdo,
  output logic                         restart,
  output logic                         busy,
  output logic                         done,
  output logic [MAXLEN-1:0]            scan_dout,
  output logic                         tck,
  output logic                         tms,
  output logic                         tdi,
  output logic                         trst_n
);

  localparam int LEN_W   = $clog2(MAXLEN + 1);
  localparam int IDX_W   = $clog2(MAXLEN);
  localparam int CNT_W   = $clog2(2 * ((1 << PAD_W) - 1) + MAXLEN + 1);
  localparam int RST_TMS = 5;

  jscan_st_e          st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               op_ir_q, notrst_q;
  logic [PAD_W-1:0]   pre_q, idle_q;
  logic [LEN_W-1:0]   len_q;
  logic [CNT_W-1:0]   total_q;
  logic [MAXLEN-1:0]  din_q, dout_d;
  logic               tck_d, tms_d, tdi_d, trst_d, busy_d, done_d;

  logic               accept, fall, rise, load;
  logic               w_ir, w_notrst;
  logic [PAD_W-1:0]   w_pre, w_post;
  logic [LEN_W-1:0]   w_len;
  logic [MAXLEN-1:0]  w_din;
  logic [CNT_W-1:0]   w_total, w_end, c_end;
  logic [IDX_W-1:0]   off_d, off_q;

  // working values: fresh inputs on acceptance, latched copy otherwise
  always_comb begin
    accept   = !busy && (start || tap_reset);
    fall     = busy && tick && tck;
    rise     = busy && tick && !tck;
    load     = accept || fall;
    restart  = accept;
    w_ir     = accept ? scan_ir     : op_ir_q;
    w_pre    = accept ? (scan_ir ? cfg.ir_pre  : cfg.dr_pre)  : pre_q;
    w_post   = accept ? (scan_ir ? cfg.ir_post : cfg.dr_post) : PAD_W'(total_q - CNT_W'(pre_q) - CNT_W'(len_q));
    w_len    = accept ? scan_len    : len_q;
    w_din    = accept ? scan_din    : din_q;
    w_notrst = accept ? cfg.no_trst : notrst_q;
    w_total  = CNT_W'(w_pre) + CNT_W'(w_len) + CNT_W'(w_post);
    w_end    = CNT_W'(w_pre) + CNT_W'(w_len);
    c_end    = CNT_W'(pre_q) + CNT_W'(len_q);
  end

  // next bit position
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (accept) begin
      st_d  = tap_reset ? ST_RST : ST_NAV;
      cnt_d = '0;
    end else if (fall) begin
      cnt_d = cnt_q + 1'b1;
      case (st_q)
        ST_NAV: if (cnt_q == (op_ir_q ? CNT_W'(3) : CNT_W'(2))) begin
          st_d = ST_SHIFT; cnt_d = '0;
        end
        ST_SHIFT: if (cnt_q == total_q - 1'b1) begin
          st_d = ST_EXIT; cnt_d = '0;
        end
        ST_EXIT, ST_RST: if ((st_q == ST_EXIT && cnt_q == CNT_W'(1)) ||
                             (st_q == ST_RST  && cnt_q == CNT_W'(RST_TMS))) begin
          st_d  = (idle_q == '0) ? ST_IDLE : ST_RTI;
          cnt_d = '0;
        end
        ST_RTI: if (cnt_q == CNT_W'(idle_q) - 1'b1) begin
          st_d = ST_IDLE; cnt_d = '0;
        end
        default: begin st_d = ST_IDLE; cnt_d = '0; end
      endcase
    end
  end

  // line values for the bit being loaded, plus capture and handshake
  always_comb begin
    off_d  = IDX_W'(cnt_d - CNT_W'(w_pre));
    off_q  = IDX_W'(cnt_q - CNT_W'(pre_q));
    tms_d  = 1'b0;
    tdi_d  = 1'b0;
    trst_d = 1'b1;
    case (st_d)
      ST_NAV:   tms_d = w_ir ? (cnt_d < CNT_W'(2)) : (cnt_d == '0);
      ST_SHIFT: begin
        tms_d = (cnt_d == w_total - 1'b1);
        if (cnt_d >= CNT_W'(w_pre) && cnt_d < w_end) tdi_d = w_din[off_d];
        else                                         tdi_d = w_ir;
      end
      ST_EXIT:  tms_d = (cnt_d == '0);
      ST_RST: begin
        tms_d  = (cnt_d < CNT_W'(RST_TMS));
        trst_d = !((cnt_d < CNT_W'(RST_TMS)) && !w_notrst);
      end
      default: ;
    endcase

    tck_d  = rise ? 1'b1 : (load ? 1'b0 : tck);
    busy_d = accept ? 1'b1 : ((fall && st_d == ST_IDLE) ? 1'b0 : busy);
    done_d = fall && (st_d == ST_IDLE);

    dout_d = scan_dout;
    if (accept) dout_d = '0;
    else if (rise && st_q == ST_SHIFT && cnt_q >= CNT_W'(pre_q) && cnt_q < c_end)
      dout_d[off_q] = tdo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      op_ir_q   <= 1'b0;
      notrst_q  <= 1'b0;
      pre_q     <= '0;
      idle_q    <= '0;
      len_q     <= '0;
      total_q   <= '0;
      din_q     <= '0;
      scan_dout <= '0;
      tck       <= 1'b0;
      tms       <= 1'b0;
      tdi       <= 1'b0;
      trst_n    <= 1'b1;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      tck       <= tck_d;
      busy      <= busy_d;
      done      <= done_d;
      scan_dout <= dout_d;
      if (load) begin
        st_q   <= st_d;
        cnt_q  <= cnt_d;
        tms    <= tms_d;
        tdi    <= tdi_d;
        trst_n <= trst_d;
      end
      if (accept) begin
        op_ir_q  <= w_ir;
        notrst_q <= w_notrst;
        pre_q    <= w_pre;
        idle_q   <= cfg.idle;
        len_q    <= w_len;
        total_q  <= w_total;
        din_q    <= w_din;
      end
    end
  end

endmodule

// File: rtl/jscan_master.sv
module jscan_master
  import jscan_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int TCK_HZ_DEF = 1_000_000,
  parameter int MAXLEN     = 64,
  parameter int PAD_W      = 8,
  parameter int DIV_W      = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [DIV_W-1:0]            cfg_half,
  input  logic [PAD_W-1:0]            cfg_ir_pre,
  input  logic [PAD_W-1:0]            cfg_ir_post,
  input  logic [PAD_W-1:0]            cfg_dr_pre,
  input  logic [PAD_W-1:0]            cfg_dr_post,
  input  logic [PAD_W-1:0]            cfg_idle,
  input  logic                        cfg_no_trst,
  input  logic                        start,
  input  logic                        tap_reset,
  input  logic                        scan_ir,
  input  logic [$clog2(MAXLEN+1)-1:0] scan_len,
  input  logic [MAXLEN-1:0]           scan_din,
  input  logic                        tdo,
  output logic                        busy,
  output logic                        done,
  output logic [MAXLEN-1:0]           scan_dout,
  output logic                        tck,
  output logic                        tms,
  output logic                        tdi,
  output logic                        trst_n
);

  jscan_cfg_t cfg_in, cfg_q;
  logic       tick, restart;

  always_comb begin
    cfg_in.half    = 16'(cfg_half);
    cfg_in.ir_pre  = cfg_ir_pre;
    cfg_in.ir_post = cfg_ir_post;
    cfg_in.dr_pre  = cfg_dr_pre;
    cfg_in.dr_post = cfg_dr_post;
    cfg_in.idle    = cfg_idle;
    cfg_in.no_trst = cfg_no_trst;
  end

  jscan_cfg_regs #(.CLK_HZ(CLK_HZ), .TCK_HZ_DEF(TCK_HZ_DEF)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .busy(busy),
    .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  jscan_tck_div #(.DIV_W(16)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(restart),
    .half(cfg_q.half), .tick(tick)
  );

  jscan_seq #(.MAXLEN(MAXLEN), .PAD_W(PAD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .start(start),
    .tap_reset(tap_reset), .scan_ir(scan_ir), .scan_len(scan_len),
    .scan_din(scan_din), .tick(tick), .tdo(tdo), .restart(restart),
    .busy(busy), .done(done), .scan_dout(scan_dout), .tck(tck),
    .tms(tms), .tdi(tdi), .trst_n(trst_n)
  );

endmodule

// File: rtl/jscan_master_chk.sv
module jscan_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic tap_reset,
  input logic busy,
  input logic done,
  input logic tck,
  input logic tms,
  input logic tdi,
  input logic trst_n
);

  // R11: lines held while the test clock stays high
  p_lines_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi)));

  // R11: clock parked low when idle
  p_tck_parked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);

  // R9: a request while idle is taken
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (start || tap_reset)) |=> busy);

  // R10: single-cycle completion pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: completion coincides with busy dropping
  p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R7: reset line only active inside an operation
  p_trst_in_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !trst_n |-> busy);

endmodule

bind jscan_master jscan_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tap_reset(tap_reset),
  .busy(busy), .done(done), .tck(tck), .tms(tms), .tdi(tdi),
  .trst_n(trst_n)
);

// File: tb/jscan_master_tb.sv
module jscan_master_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 190000;
  localparam int CW         = 640;

  // chain model states
  localparam int TLR = 0, RTI = 1, SELDR = 2, CAPDR = 3, SHDR = 4, EX1DR = 5,
                 PADR = 6, EX2DR = 7, UPDR = 8, SELIR = 9, CAPIR = 10,
                 SHIR = 11, EX1IR = 12, PAIR = 13, EX2IR = 14, UPIR = 15;

  typedef struct packed {
    logic        ir;
    logic [6:0]  len;
    logic [7:0]  pre;
    logic [7:0]  post;
    logic [63:0] din;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 7'd5,  8'd8, 8'd0, 64'h0000_0000_0000_0015},
    '{1'b1, 7'd3,  8'd3, 8'd4, 64'h0000_0000_0000_0005},
    '{1'b1, 7'd4,  8'd0, 8'd9, 64'h0000_0000_0000_000A},
    '{1'b0, 7'd32, 8'd2, 8'd0, 64'h0000_0000_DEAD_BEEF},
    '{1'b0, 7'd64, 8'd1, 8'd1, 64'hA5A5_0F0F_1234_8001},
    '{1'b0, 7'd1,  8'd0, 8'd0, 64'h0000_0000_0000_0001},
    '{1'b1, 7'd64, 8'd0, 8'd0, 64'hFFFF_0000_C3C3_7E81}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_half = '0;
  logic [7:0]  cfg_ir_pre = '0, cfg_ir_post = '0, cfg_dr_pre = '0, cfg_dr_post = '0;
  logic [7:0]  cfg_idle = '0;
  logic        cfg_no_trst = 1'b0;
  logic        start = 1'b0, tap_reset = 1'b0, scan_ir = 1'b0;
  logic [6:0]  scan_len = '0;
  logic [63:0] scan_din = '0;
  logic        tdo;
  logic        busy, done, tck, tms, tdi, trst_n;
  logic [63:0] scan_dout;

  int n_chk = 0, n_bad = 0, cyc = 0;

  // chain model state
  int          tap_st = RTI;
  logic [CW-1:0] chain = '0, tmp_c;
  int          m_total = 1;
  int          tck_cnt = 0, trst_low_tck = 0, trst_falls = 0;
  int          m_last = 0, m_prd = 0;
  logic        tms_log [1024];

  assign tdo = chain[0];

  jscan_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_half(cfg_half),
    .cfg_ir_pre(cfg_ir_pre), .cfg_ir_post(cfg_ir_post),
    .cfg_dr_pre(cfg_dr_pre), .cfg_dr_post(cfg_dr_post),
    .cfg_idle(cfg_idle), .cfg_no_trst(cfg_no_trst), .start(start),
    .tap_reset(tap_reset), .scan_ir(scan_ir), .scan_len(scan_len),
    .scan_din(scan_din), .tdo(tdo), .busy(busy), .done(done),
    .scan_dout(scan_dout), .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic cap_bit(input int k);
    return ((k * 7 + k / 3) % 5) < 2;
  endfunction

  function automatic int nxt(input int s, input logic m);
    case (s)
      TLR:   return m ? TLR   : RTI;
      RTI:   return m ? SELDR : RTI;
      SELDR: return m ? SELIR : CAPDR;
      CAPDR: return m ? EX1DR : SHDR;
      SHDR:  return m ? EX1DR : SHDR;
      EX1DR: return m ? UPDR  : PADR;
      PADR:  return m ? EX2DR : PADR;
      EX2DR: return m ? UPDR  : SHDR;
      UPDR:  return m ? SELDR : RTI;
      SELIR: return m ? TLR   : CAPIR;
      CAPIR: return m ? EX1IR : SHIR;
      SHIR:  return m ? EX1IR : SHIR;
      EX1IR: return m ? UPIR  : PAIR;
      PAIR:  return m ? EX2IR : PAIR;
      EX2IR: return m ? UPIR  : SHIR;
      default: return m ? SELDR : RTI;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act %0d cycles exp below %0d", cyc, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  always @(negedge trst_n) trst_falls++;

  always @(posedge tck) begin
    m_prd  = cyc - m_last;
    m_last = cyc;
    tms_log[tck_cnt % 1024] = tms;
    tck_cnt++;
    if (!trst_n) begin
      trst_low_tck++;
      tap_st = TLR;
    end else begin
      if (tap_st == SHIR || tap_st == SHDR) begin
        tmp_c = chain >> 1;
        tmp_c[m_total-1] = tdi;
        chain <= tmp_c;
      end else if (tap_st == CAPIR || tap_st == CAPDR) begin
        for (int k = 0; k < CW; k++) tmp_c[k] = cap_bit(k);
        chain <= tmp_c;
      end
      tap_st = nxt(tap_st, tms);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int half, input int irp, input int irq, input int drp,
                         input int drq, input int idle, input bit nt);
    @(negedge clk);
    cfg_half = 16'(half); cfg_ir_pre = 8'(irp); cfg_ir_post = 8'(irq);
    cfg_dr_pre = 8'(drp); cfg_dr_post = 8'(drq); cfg_idle = 8'(idle);
    cfg_no_trst = nt; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_logs();
    tck_cnt = 0; trst_low_tck = 0; trst_falls = 0;
  endtask

  task automatic wait_done(output bit ok_busy, output bit ok_pulse);
    while (!done) @(negedge clk);
    ok_busy = !busy;
    @(negedge clk);
    ok_pulse = !done;
  endtask

  task automatic launch(input bit ir, input int len, input logic [63:0] din, input int total);
    m_total = total;
    clear_logs();
    @(negedge clk);
    scan_ir = ir; scan_len = 7'(len); scan_din = din; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_scan(input bit ir, input int len, input int pre, input int post,
                            input logic [63:0] din, input int idle);
    logic [63:0] e_out;
    int          total, nav, errs, pos;
    logic        e;
    string       rq;
    rq    = ir ? "R3" : "R4";
    total = pre + len + post;
    nav   = ir ? 4 : 3;
    e_out = '0;
    for (int i = 0; i < len; i++) e_out[i] = cap_bit(pre + i);
    chk(scan_dout == e_out, "R5 captured target bits", scan_dout, e_out);
    errs = 0;
    for (int k = 0; k < total; k++) begin
      e = (k < pre || k >= pre + len) ? ir : din[k - pre];
      if (chain[k] !== e) errs++;
    end
    chk(errs == 0, {rq, " shifted frame"}, 64'(errs), 64'd0);
    errs = 0; pos = 0;
    for (int k = 0; k < nav; k++) begin
      e = ir ? (k < 2) : (k == 0);
      if (tms_log[pos] !== e) errs++;
      pos++;
    end
    for (int k = 0; k < total; k++) begin
      if (tms_log[pos] !== (k == total - 1)) errs++;
      pos++;
    end
    if (tms_log[pos] !== 1'b1) errs++;
    if (tms_log[pos+1] !== 1'b0) errs++;
    pos += 2;
    for (int k = 0; k < idle; k++) begin
      if (tms_log[pos] !== 1'b0) errs++;
      pos++;
    end
    chk(errs == 0, {rq, " mode-select sequence"}, 64'(errs), 64'd0);
    chk(tck_cnt == nav + total + 2 + idle, "R6 clock count with idle", 64'(tck_cnt),
        64'(nav + total + 2 + idle));
    chk(tap_st == RTI, {rq, " ends in Run-Test/Idle"}, 64'(tap_st), 64'(RTI));
  endtask

  initial begin
    bit ob, op;
    int saved;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    chk(!busy && !done && !tck && trst_n && scan_dout == '0, "R1 reset outputs",
        {59'd0, busy, done, tck, trst_n, |scan_dout}, 64'h2);

    // R7 and R2 default rate: port reset with reset line, default settings
    m_total = 1;
    clear_logs();
    @(negedge clk); tap_reset = 1'b1;
    @(negedge clk); tap_reset = 1'b0;
    wait_done(ob, op);
    chk(ob && op, "R10 done pulse with busy low", {62'd0, ob, op}, 64'h3);
    chk(m_prd == 100, "R1 R2 default clock period", 64'(m_prd), 64'd100);
    chk(trst_falls == 1 && trst_low_tck == 5, "R7 reset line pulse",
        64'(trst_falls * 16 + trst_low_tck), 64'(16 + 5));
    chk(tck_cnt == 6 && tap_st == RTI, "R7 reset sequence",
        64'(tck_cnt * 16 + tap_st), 64'(6 * 16 + RTI));

    // vector table: instruction and data scans at a faster rate
    for (int v = 0; v < NV; v++) begin
      if (VEC[v].ir)
        set_cfg(2, VEC[v].pre, VEC[v].post, VEC[v].pre + 3, VEC[v].post + 5, v, 1'b0);
      else
        set_cfg(2, VEC[v].pre + 2, VEC[v].post + 6, VEC[v].pre, VEC[v].post, v, 1'b0);
      launch(VEC[v].ir, VEC[v].len, VEC[v].din, VEC[v].pre + VEC[v].len + VEC[v].post);
      wait_done(ob, op);
      chk(ob && op, "R10 done pulse", {62'd0, ob, op}, 64'h3);
      check_scan(VEC[v].ir, VEC[v].len, VEC[v].pre, VEC[v].post, VEC[v].din, v);
      if (v == 0) chk(m_prd == 4, "R2 programmed clock period", 64'(m_prd), 64'd4);
    end

    // R9 and R2: requests and settings written while busy
    set_cfg(2, 1, 1, 2, 1, 1, 1'b0);
    launch(1'b0, 16, 64'h0000_0000_0000_BEEF, 2 + 16 + 1);
    repeat (20) @(negedge clk);
    scan_din = 64'h1234; cfg_half = 16'd9; cfg_dr_pre = 8'd7; cfg_idle = 8'd0;
    start = 1'b1; cfg_we = 1'b1;
    @(negedge clk);
    start = 1'b0; cfg_we = 1'b0;
    scan_din = 64'h0000_0000_0000_BEEF;
    wait_done(ob, op);
    saved = tck_cnt;
    repeat (60) @(negedge clk);
    chk(!busy && tck_cnt == saved, "R9 no second operation", 64'(tck_cnt), 64'(saved));
    check_scan(1'b0, 16, 2, 1, 64'h0000_0000_0000_BEEF, 1);
    launch(1'b0, 16, 64'h0000_0000_0000_BEEF, 2 + 16 + 1);
    wait_done(ob, op);
    chk(m_prd == 4, "R2 write while busy ignored", 64'(m_prd), 64'd4);
    check_scan(1'b0, 16, 2, 1, 64'h0000_0000_0000_BEEF, 1);

    // R8: mode-select-only reset from a pause state
    set_cfg(2, 0, 0, 0, 0, 3, 1'b1);
    tap_st = PADR;
    m_total = 1;
    clear_logs();
    @(negedge clk); tap_reset = 1'b1;
    @(negedge clk); tap_reset = 1'b0;
    wait_done(ob, op);
    chk(trst_falls == 0 && trst_n, "R8 reset line stays high", 64'(trst_falls), 64'd0);
    chk(tap_st == RTI && tck_cnt == 9, "R8 reached Run-Test/Idle",
        64'(tap_st * 256 + tck_cnt), 64'(RTI * 256 + 9));
    chk(tms_log[0] && tms_log[1] && tms_log[2] && tms_log[3] && tms_log[4] && !tms_log[5],
        "R8 five mode-select highs", {63'd0, tms_log[4]}, 64'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule